// File: doc/BRIEF.md
# Binary to residue forward converter

This block maps an unsigned binary word onto three residues for the moduli 2^n-1, 2^n and 2^n+1. The word width n is a parameter. The input, which may be narrower than 3n bits, is zero-extended to 3n bits and cut into three n-bit slices: a high slice H, a middle slice M and a low slice L, so that X = H·2^(2n) + M·2^n + L. No divider is used. The residue modulo 2^n is simply L. The residue modulo 2^n-1 is the sum of the three slices taken modulo 2^n-1. The residue modulo 2^n+1 is H - M + L taken modulo 2^n+1. Each of those two sums is built from a chain of two two-input modular adders.

A caller presents one word with `in_valid` high. Exactly one clock later, the three residues appear on registered outputs with `out_valid` high. While `in_valid` is low, the outputs keep their last values. The block is used with n=2 (moduli 3, 4 and 5, for a 5-bit exponent) and with n=8 (moduli 255, 256 and 257, for a 10-bit mantissa).

Top module: `rns_fwd_conv`

## Requirements
- R1: `res_pow` equals X mod 2^n, which is the low n bits of the input word.
- R2: `res_m1` equals X mod (2^n-1) in canonical form, in the range 0 to 2^n-2. The all-ones value never appears.
- R3: `res_p1` is n+1 bits wide and equals X mod (2^n+1), in the range 0 to 2^n.
- R4: An input narrower than 3n bits is zero-extended. With n=8 and a 10-bit input, every word from 0 to 1023 gives the correct three residues.
- R5: With n=2 and a 5-bit input, every word from 0 to 31 gives the correct three residues.
- R6: `out_valid` equals `in_valid` delayed by exactly one clock. Words presented on back-to-back cycles each produce their own result on the following cycle.
- R7: A synchronous active-high `rst` clears `out_valid` and all three residue outputs to 0.
- R8: While `in_valid` is low, the residue outputs hold their previous values, whatever `in_data` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is present this cycle |
| in_data | input | DW | Unsigned input word, DW ≤ 3·N |
| out_valid | output | 1 | Residues are valid this cycle |
| res_m1 | output | N | Residue modulo 2^N-1 |
| res_pow | output | N | Residue modulo 2^N |
| res_p1 | output | N+1 | Residue modulo 2^N+1 |

## Verification
For both widths, the whole input space is swept back to back, with the expected residues computed by integer remainder. This exposes any wrong slice boundary, a missing modulus subtraction, or an error in the zero case of the negation.

A small table of hand-picked words checks the known corners:
- 255, 510 and 1023 show the all-ones folding of the 2^n-1 residue.
- 256, 257, 512 and 771 show the borrow behaviour of the 2^n+1 residue.

Directed steps then separate a hold on an idle input from a recapture, and check that reset clears every output.

// File: rtl/rns_fwd_pkg.sv
package rns_fwd_pkg;
    // Modulus values for a given slice width
    function automatic int mod_minus(input int n);
        return (1 << n) - 1;
    endfunction

    function automatic int mod_plus(input int n);
        return (1 << n) + 1;
    endfunction
endpackage

// File: rtl/rns_add_m1.sv
module rns_add_m1 #(
    parameter int N = 8
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] s
);
    import rns_fwd_pkg::*;

    localparam logic [N:0] MODV = (N+1)'(mod_minus(N));

    logic [N:0] sum_d;
    logic [N:0] red_d;

    always_comb begin
        sum_d = {1'b0, a} + {1'b0, b};
        if (sum_d >= MODV) begin
            red_d = sum_d - MODV;
        end else begin
            red_d = sum_d;
        end
        s = red_d[N-1:0];
    end

    // R2: the reduced sum never carries past n bits
    always_comb begin
        a_r2_no_overflow: assert (red_d[N] == 1'b0);
    end
endmodule

// File: rtl/rns_add_p1.sv
module rns_add_p1 #(
    parameter int N = 8
) (
    input  logic [N:0] a,
    input  logic [N:0] b,
    output logic [N:0] s
);
    import rns_fwd_pkg::*;

    localparam logic [N+1:0] MODV = (N+2)'(mod_plus(N));

    logic [N+1:0] sum_d;
    logic [N+1:0] red_d;

    always_comb begin
        sum_d = {1'b0, a} + {1'b0, b};
        if (sum_d >= MODV) begin
            red_d = sum_d - MODV;
        end else begin
            red_d = sum_d;
        end
        s = red_d[N:0];
    end

    // R3: operands in range give a result below the modulus
    always_comb begin
        if ({1'b0, a} < MODV && {1'b0, b} < MODV) begin
            a_r3_sum_in_range: assert (red_d < MODV);
        end
    end
endmodule

// File: rtl/rns_fwd_conv.sv
module rns_fwd_conv #(
    parameter int N  = 8,
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [N-1:0]  res_m1,
    output logic [N-1:0]  res_pow,
    output logic [N:0]    res_p1
);
    import rns_fwd_pkg::*;

    localparam int         XW     = 3 * N;
    localparam logic [N:0] MOD_P1 = (N+1)'(mod_plus(N));

    typedef struct packed {
        logic         vld;
        logic [N-1:0] m1;
        logic [N-1:0] pw;
        logic [N:0]   p1;
    } res_t;

    res_t state_d, state_q;

    logic [XW-1:0] ext_d;
    logic [N-1:0]  blk_hi, blk_mid, blk_lo;
    logic [N:0]    neg_mid;
    logic [N-1:0]  m1_first, m1_second;
    logic [N:0]    p1_first, p1_second;

    // Zero-extend the input and cut it into slices
    always_comb begin
        ext_d          = '0;
        ext_d[DW-1:0]  = in_data;
        blk_hi         = ext_d[3*N-1:2*N];
        blk_mid        = ext_d[2*N-1:N];
        blk_lo         = ext_d[N-1:0];
        if (blk_mid == '0) begin
            neg_mid = '0;
        end else begin
            neg_mid = MOD_P1 - {1'b0, blk_mid};
        end
    end

    // Modulo 2^n-1 chain: hi + mid, then + lo
    rns_add_m1 #(.N(N)) u_m1_a (.a(blk_hi),   .b(blk_mid), .s(m1_first));
    rns_add_m1 #(.N(N)) u_m1_b (.a(m1_first), .b(blk_lo),  .s(m1_second));

    // Modulo 2^n+1 chain: hi - mid, then + lo
    rns_add_p1 #(.N(N)) u_p1_a (.a({1'b0, blk_hi}), .b(neg_mid),         .s(p1_first));
    rns_add_p1 #(.N(N)) u_p1_b (.a(p1_first),       .b({1'b0, blk_lo}),  .s(p1_second));

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.pw = blk_lo;
            state_d.m1 = (m1_second == '1) ? '0 : m1_second;
            state_d.p1 = p1_second;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign res_m1    = state_q.m1;
    assign res_pow   = state_q.pw;
    assign res_p1    = state_q.p1;

    // R6: out_valid tracks in_valid one clock later
    a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r6_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R1: low residue is the low slice of the captured word
    a_r1_low_slice: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (res_pow == $past(in_data[N-1:0])));

    // R2: canonical form, the all-ones value is never shown
    a_r2_canonical: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (res_m1 != '1));

    // R3: residue stays within 0 .. 2^n
    a_r3_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (res_p1 < MOD_P1));

    // R8: outputs hold on idle cycles
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res_m1) && $stable(res_pow) && $stable(res_p1)));
endmodule

// File: tb/rns_fwd_conv_test.sv
module rns_fwd_conv_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Wide instance: n=8, 10-bit input
    logic        vl_in = 1'b0;
    logic [9:0]  dl_in = '0;
    logic        vl_out;
    logic [7:0]  l_m1, l_pw;
    logic [8:0]  l_p1;

    // Narrow instance: n=2, 5-bit input
    logic        vs_in = 1'b0;
    logic [4:0]  ds_in = '0;
    logic        vs_out;
    logic [1:0]  s_m1, s_pw;
    logic [2:0]  s_p1;

    rns_fwd_conv #(.N(8), .DW(10)) uut (
        .clk(clk), .rst(rst), .in_valid(vl_in), .in_data(dl_in),
        .out_valid(vl_out), .res_m1(l_m1), .res_pow(l_pw), .res_p1(l_p1));

    rns_fwd_conv #(.N(2), .DW(5)) uut_exp (
        .clk(clk), .rst(rst), .in_valid(vs_in), .in_data(ds_in),
        .out_valid(vs_out), .res_m1(s_m1), .res_pow(s_pw), .res_p1(s_p1));

    // Hand-picked corners for n=8: {x, mod255, mod256, mod257}
    localparam int NV = 8;
    localparam int VEC [NV][4] = '{
        '{0,    0, 0,   0},
        '{255,  0, 255, 255},
        '{256,  1, 0,   256},
        '{257,  2, 1,   0},
        '{510,  0, 254, 253},
        '{512,  2, 0,   255},
        '{771,  6, 3,   0},
        '{1023, 3, 255, 252}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic print_summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            print_summary();
            $finish;
        end
    end

    initial begin
        int hold_m1, hold_pw, hold_p1;
        repeat (3) @(negedge clk);

        // R7: reset state
        check("R7 reset out_valid", int'(vl_out), 0);
        check("R7 reset res_m1", int'(l_m1), 0);
        check("R7 reset res_pow", int'(l_pw), 0);
        check("R7 reset res_p1", int'(l_p1), 0);
        rst = 1'b0;
        @(negedge clk);

        // Table walk, back to back (R1 R2 R3 R6)
        for (int i = 0; i < NV; i++) begin
            vl_in = 1'b1;
            dl_in = 10'(VEC[i][0]);
            @(negedge clk);
            check("R6 out_valid", int'(vl_out), 1);
            check("R2 table res_m1", int'(l_m1), VEC[i][1]);
            check("R1 table res_pow", int'(l_pw), VEC[i][2]);
            check("R3 table res_p1", int'(l_p1), VEC[i][3]);
        end
        vl_in = 1'b0;
        @(negedge clk);
        check("R6 idle out_valid", int'(vl_out), 0);

        // R4: full sweep of the 10-bit space, n=8
        for (int x = 0; x < 1024; x++) begin
            vl_in = 1'b1;
            dl_in = 10'(x);
            @(negedge clk);
            check("R4 sweep res_m1", int'(l_m1), x % 255);
            check("R4 sweep res_pow", int'(l_pw), x % 256);
            check("R4 sweep res_p1", int'(l_p1), x % 257);
        end
        vl_in = 1'b0;

        // R5: full sweep of the 5-bit space, n=2
        for (int x = 0; x < 32; x++) begin
            vs_in = 1'b1;
            ds_in = 5'(x);
            @(negedge clk);
            check("R5 sweep out_valid", int'(vs_out), 1);
            check("R5 sweep res_m1", int'(s_m1), x % 3);
            check("R5 sweep res_pow", int'(s_pw), x % 4);
            check("R5 sweep res_p1", int'(s_p1), x % 5);
        end
        vs_in = 1'b0;

        // R8: idle input with changing data leaves outputs alone
        vl_in = 1'b1;
        dl_in = 10'd771;
        @(negedge clk);
        hold_m1 = 6; hold_pw = 3; hold_p1 = 0;
        vl_in = 1'b0;
        dl_in = 10'd1023;
        repeat (2) @(negedge clk);
        check("R8 hold out_valid", int'(vl_out), 0);
        check("R8 hold res_m1", int'(l_m1), hold_m1);
        check("R8 hold res_pow", int'(l_pw), hold_pw);
        check("R8 hold res_p1", int'(l_p1), hold_p1);

        // R6: a single word after idle is captured again
        vl_in = 1'b1;
        @(negedge clk);
        vl_in = 1'b0;
        check("R6 recapture res_m1", int'(l_m1), 3);
        check("R6 recapture res_p1", int'(l_p1), 252);
        @(negedge clk);
        check("R6 single pulse ends", int'(vl_out), 0);

        // R7: reset in mid-run clears outputs
        vl_in = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check("R7 mid reset out_valid", int'(vl_out), 0);
        check("R7 mid reset res_m1", int'(l_m1), 0);
        check("R7 mid reset res_pow", int'(l_pw), 0);
        check("R7 mid reset res_p1", int'(l_p1), 0);
        vl_in = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        print_summary();
        $finish;
    end
endmodule